// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs register reads and writes to an Ethernet PHY over the two-wire management bus. It produces the management clock (MDC) itself, by dividing the system clock. It drives the data line through three separate pad signals: a value to drive, an output enable and a sampled input. The block sends a preamble of all-ones bits first. It then shifts out the start and opcode bits, the PHY address, the register number and, for a write, the turnaround and the data word. For a read it releases the line, samples sixteen data bits and then runs three extra clock periods whose data it ignores.

A request is taken over a valid/ready handshake. `req_ready` is high only while the block is idle. A request offered while a frame is running is not taken and has no effect; the host must hold `req_valid` until it sees `req_ready`. The response is a one-cycle strobe with no back-pressure. It rises in the cycle after the last management clock period ends, and `req_ready` is already high in that same cycle. `req_ext` picks one of two PHY targets. Each target has its own fixed PHY address, and each samples read data at a different point of the clock period: the external PHY just before MDC rises, the internal PHY just after it rises.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no frame is running: `mdc` is low, `mdio_oe` is low, `mdio_o` is high, `req_ready` is high and `rsp_valid` is low.
- R2: Every frame starts with PRE_LEN clock periods of preamble, with `mdio_oe` high and `mdio_o` high.
- R3: After the preamble come four driven bits. A write sends 0,1,0,1 and a read sends 0,1,1,0.
- R4: Next come ten driven bits, MSB first: the 5-bit PHY address and then the 5-bit `req_reg`. The address is EXT_ADDR (default 0) when `req_ext` is 1 and INT_ADDR (default 1) when `req_ext` is 0.
- R5: A write then drives turnaround bits 1,0 and the 16 bits of `req_wdata`, MSB first. A write frame is PRE_LEN+32 periods long and `mdio_oe` stays high for all of it.
- R6: A read then releases the line (`mdio_oe` low, `mdio_o` high) for 2 turnaround periods, 16 data periods and 3 trailing periods. A read frame is PRE_LEN+35 periods long.
- R7: With `req_ext`=1, each read data bit is the value of `mdio_i` in the last system cycle before `mdc` rises. Bits are assembled MSB first into `rsp_rdata`.
- R8: With `req_ext`=0, each read data bit is the value of `mdio_i` in the first system cycle with `mdc` high. Bits are assembled MSB first.
- R9: Each clock period is HALF_DIV system cycles with `mdc` low followed by HALF_DIV cycles with `mdc` high. `mdio_o` and `mdio_oe` change only into a cycle where `mdc` is low.
- R10: `req_ready` is low while a frame runs. A request offered then is not accepted and does not change the running frame or the next one.
- R11: `rsp_valid` is high for exactly one cycle: the cycle after the last system cycle of the final period. In that cycle `rsp_rdata` holds the read word and `req_ready` is high, so a held request is accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_reg | input | 5 | PHY register number |
| req_wdata | input | 16 | Write data |
| req_ext | input | 1 | 1 = external PHY target, 0 = internal |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid after a read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value for the pad |
| mdio_oe | output | 1 | Pad output enable |
| mdio_i | input | 1 | Data sampled from the pad |

## Verification
Two events can fall in the same cycle: a frame completing (`rsp_valid`) and a new request being accepted. The bench provokes this by holding `req_valid` high for a second request from before the first frame ends. The reference model then expects `req_ready` to stay low through the final period, expects the strobe and ready together, and expects the new preamble to start one cycle later. It also shows that a request pulsed in the middle of a frame leaves both frames untouched. For reads, the bench drives `mdio_i` to one pattern while `mdc` is low and a different pattern while it is high. The two targets must therefore return different words, which separates the two sampling points.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W    = 5;
  localparam int REG_W     = 5;
  localparam int DATA_W    = 16;
  localparam int HDR_BITS  = 4 + ADDR_W + REG_W;
  localparam int TA_BITS   = 2;
  localparam int TAIL_BITS = 3;
  localparam int FRAME_W   = HDR_BITS + TA_BITS + DATA_W;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;
endpackage

// File: rtl/mdio_bit_timer.sv
module mdio_bit_timer #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic period_end,
  output logic smp_before,
  output logic smp_after
);
  localparam int PER = 2 * HALF_DIV;
  localparam int CW  = (PER > 2) ? $clog2(PER) : 1;
  localparam logic [CW-1:0] C_END  = CW'(PER - 1);
  localparam logic [CW-1:0] C_RISE = CW'(HALF_DIV);
  localparam logic [CW-1:0] C_PRE  = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run)         cnt <= '0;
    else if (cnt == C_END) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign mdc        = run && (cnt >= C_RISE);
  assign period_end = run && (cnt == C_END);
  assign smp_before = run && (cnt == C_PRE);
  assign smp_after  = run && (cnt == C_RISE);
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
#(
  parameter int                PRE_LEN  = 32,
  parameter logic [ADDR_W-1:0] INT_ADDR = 5'd1,
  parameter logic [ADDR_W-1:0] EXT_ADDR = 5'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_ext,
  input  logic              period_end,
  output logic              busy,
  output logic              mdo,
  output logic              mdo_en,
  output logic              rd_win,
  output logic              tgt_ext,
  output logic              done
);
  localparam int MAXB = PRE_LEN + FRAME_W + TAIL_BITS;
  localparam int BW   = $clog2(MAXB + 1);
  localparam logic [BW-1:0] PRE_B   = BW'(PRE_LEN);
  localparam logic [BW-1:0] LAST_WR = BW'(PRE_LEN + FRAME_W - 1);
  localparam logic [BW-1:0] LAST_RD = BW'(MAXB - 1);
  localparam logic [BW-1:0] HDR_B   = BW'(HDR_BITS);
  localparam logic [BW-1:0] DAT_LO  = BW'(HDR_BITS + TA_BITS);
  localparam logic [BW-1:0] DAT_HI  = BW'(FRAME_W);

  logic [BW-1:0]      bitn;
  logic [FRAME_W-1:0] frame;
  logic               wr;
  logic [BW-1:0]      last_bit;
  logic [BW-1:0]      idx;
  logic [4:0]         pos;
  logic               in_pre;
  mdio_op_e           op;

  assign op       = req_write ? OP_WRITE : OP_READ;
  assign last_bit = wr ? LAST_WR : LAST_RD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bitn    <= '0;
      frame   <= '0;
      wr      <= 1'b0;
      tgt_ext <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= busy && period_end && (bitn == last_bit);
      if (!busy) begin
        if (req_valid) begin
          busy    <= 1'b1;
          bitn    <= '0;
          wr      <= req_write;
          tgt_ext <= req_ext;
          frame   <= {2'b01, op, (req_ext ? EXT_ADDR : INT_ADDR), req_reg,
                      (req_write ? {2'b10, req_wdata} : {(TA_BITS + DATA_W){1'b1}})};
        end
      end else if (period_end) begin
        if (bitn == last_bit) busy <= 1'b0;
        else                  bitn <= bitn + 1'b1;
      end
    end
  end

  assign in_pre = bitn < PRE_B;
  assign idx    = bitn - PRE_B;
  assign pos    = 5'(FRAME_W - 1) - idx[4:0];

  always_comb begin
    mdo    = 1'b1;
    mdo_en = 1'b0;
    if (busy) begin
      if (in_pre) begin
        mdo_en = 1'b1;
      end else if (wr || (idx < HDR_B)) begin
        mdo_en = 1'b1;
        mdo    = frame[pos];
      end
    end
  end

  assign rd_win = busy && !wr && !in_pre && (idx >= DAT_LO) && (idx < DAT_HI);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_frame_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !period_end) |=> busy);
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_win,
  input  logic              tgt_ext,
  input  logic              smp_before,
  input  logic              smp_after,
  input  logic              mdio_i,
  output logic [DATA_W-1:0] rdata
);
  logic take;

  assign take = rd_win && (tgt_ext ? smp_before : smp_after);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata <= '0;
    else if (take) rdata <= {rdata[DATA_W-2:0], mdio_i};
  end

  assert_one_sample_point_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({smp_before, smp_after}));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int                HALF_DIV = 2,
  parameter int                PRE_LEN  = 32,
  parameter logic [ADDR_W-1:0] INT_ADDR = 5'd1,
  parameter logic [ADDR_W-1:0] EXT_ADDR = 5'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_ext,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic busy, period_end, smp_before, smp_after, rd_win, tgt_ext;

  mdio_bit_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .mdc(mdc),
    .period_end(period_end), .smp_before(smp_before), .smp_after(smp_after)
  );

  mdio_frame_ctrl #(.PRE_LEN(PRE_LEN), .INT_ADDR(INT_ADDR), .EXT_ADDR(EXT_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_reg(req_reg), .req_wdata(req_wdata), .req_ext(req_ext),
    .period_end(period_end), .busy(busy), .mdo(mdio_o), .mdo_en(mdio_oe),
    .rd_win(rd_win), .tgt_ext(tgt_ext), .done(rsp_valid)
  );

  mdio_rx_capture u_cap (
    .clk(clk), .rst_n(rst_n), .rd_win(rd_win), .tgt_ext(tgt_ext),
    .smp_before(smp_before), .smp_after(smp_after), .mdio_i(mdio_i),
    .rdata(rsp_rdata)
  );

  assign req_ready = !busy;

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe && mdio_o));
  assert_data_moves_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mdio_o) || !$stable(mdio_oe)) |-> !mdc);
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int H   = 2;
  localparam int PRE = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ext = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #2 clk = ~clk;

  mdio_master #(.HALF_DIV(H), .PRE_LEN(PRE), .INT_ADDR(5'd1), .EXT_ADDR(5'd0)) u_mdio_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_reg(req_reg), .req_wdata(req_wdata), .req_ext(req_ext),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // pattern driven by the PHY model: pat_lo while mdc low, pat_hi while high
  logic [15:0] pat_lo = '0, pat_hi = '0;

  // reference model state
  bit          m_busy = 0, m_done = 0, m_wr = 0, m_ext = 0;
  int          m_cnt = 0, m_bit = 0, m_n = 0;
  bit          e_o[0:127];
  bit          e_oe[0:127];
  logic [15:0] m_lo, m_hi;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic put(input bit o, input bit oe);
    e_o[m_n] = o;
    e_oe[m_n] = oe;
    m_n++;
  endtask

  task automatic build(input bit wr, input bit ext, input logic [4:0] rg, input logic [15:0] wd);
    logic [4:0] pa;
    pa = ext ? 5'd0 : 5'd1;
    m_n = 0;
    for (int i = 0; i < PRE; i++) put(1, 1);
    put(0, 1); put(1, 1);
    if (wr) begin put(0, 1); put(1, 1); end
    else    begin put(1, 1); put(0, 1); end
    for (int i = 4; i >= 0; i--) put(pa[i], 1);
    for (int i = 4; i >= 0; i--) put(rg[i], 1);
    if (wr) begin
      put(1, 1); put(0, 1);
      for (int i = 15; i >= 0; i--) put(wd[i], 1);
    end else begin
      for (int i = 0; i < 21; i++) put(1, 0);
    end
  endtask

  function automatic string region_tag(input int b);
    if (b < PRE) return "R2";
    if (b < PRE + 4) return "R3";
    if (b < PRE + 14) return "R4";
    return m_wr ? "R5" : "R6";
  endfunction

  // cycle-by-cycle model, stepped mid-cycle
  always @(negedge clk) begin
    bit x_mdc, x_o, x_oe;
    string tg;
    m_done = 0;
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_bit = 0;
    end else if (m_busy) begin
      if (m_cnt == 2*H-1) begin
        if (m_bit == m_n-1) begin m_busy = 0; m_done = 1; end
        else begin m_bit++; m_cnt = 0; end
      end else m_cnt++;
    end else if (req_valid) begin
      m_busy = 1; m_cnt = 0; m_bit = 0;
      m_wr = req_write; m_ext = req_ext;
      m_lo = pat_lo; m_hi = pat_hi;
      build(req_write, req_ext, req_reg, req_wdata);
    end
    x_mdc = m_busy && (m_cnt >= H);
    x_o   = m_busy ? e_o[m_bit] : 1'b1;
    x_oe  = m_busy ? e_oe[m_bit] : 1'b0;
    tg    = m_busy ? region_tag(m_bit) : "R1";
    chk(m_busy ? "R9" : "R1", "mdc", int'(mdc), int'(x_mdc));
    chk(tg, "mdio_o", int'(mdio_o), int'(x_o));
    chk(tg, "mdio_oe", int'(mdio_oe), int'(x_oe));
    chk(m_busy ? "R10" : "R1", "req_ready", int'(req_ready), int'(!m_busy));
    chk("R11", "rsp_valid", int'(rsp_valid), int'(m_done));
    if (m_done && !m_wr)
      chk(m_ext ? "R7" : "R8", "rsp_rdata", int'(rsp_rdata), int'(m_ext ? m_lo : m_hi));
    // PHY side: drive read data bits
    if (m_busy && !m_wr && m_bit >= PRE+16 && m_bit < PRE+32)
      mdio_i = x_mdc ? m_hi[15-(m_bit-PRE-16)] : m_lo[15-(m_bit-PRE-16)];
    else
      mdio_i = 1'b1;
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic issue(input bit wr, input bit ext, input logic [4:0] rg,
                       input logic [15:0] wd, input logic [15:0] lo, input logic [15:0] hi);
    bit acc;
    req_write = wr; req_ext = ext; req_reg = rg; req_wdata = wd;
    pat_lo = lo; pat_hi = hi;
    req_valid = 1'b1;
    forever begin
      acc = req_ready;
      step();
      if (acc) break;
    end
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!req_ready) step();
    step();
  endtask

  initial begin
    repeat (5) step();
    rst_n = 1'b1;
    repeat (3) step();
    // R5 writes to both targets; second request held so it lands with the first done (R11)
    issue(1, 0, 5'h00, 16'hA5C3, 16'h0, 16'h0);
    issue(1, 1, 5'h1F, 16'h8001, 16'h0, 16'h0);
    wait_idle();
    // R7 external read, then a request pulsed mid-frame that must be ignored (R10)
    issue(0, 1, 5'h01, 16'h0, 16'hC3A5, 16'h5A3C);
    repeat (10) step();
    req_write = 1; req_ext = 0; req_reg = 5'h0A; req_wdata = 16'hFFFF;
    req_valid = 1'b1;
    repeat (4) step();
    req_valid = 1'b0;
    wait_idle();
    // R8 internal reads with distinct low/high patterns
    issue(0, 0, 5'h10, 16'h0, 16'hFFFF, 16'h0000);
    issue(0, 0, 5'h15, 16'h0, 16'h0000, 16'hF0F1);
    wait_idle();
    issue(0, 1, 5'h02, 16'h0, 16'h8421, 16'h0000);
    wait_idle();
    repeat (10) step();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule